// File: doc/BRIEF.md
# Timer-Compare Interrupt and Status Unit

This block holds the system-control state that decides whether a processor core gets interrupted. A free-running count register advances on every enabled tick. Software loads a compare register, and the tick on which the count reaches that value marks the timer interrupt pending. The pending mark stays set until software writes the compare register again. Any such write clears it, whatever value is written.

A status register holds the global interrupt enable, the exception-level and error-level flags, an 8-bit interrupt mask and a few mode fields. A cause register shows eight pending sources: the timer, five hardware lines and two software bits. Each source is gated by its own mask bit. The surviving sources are then gated by the global enable and by both level flags, which gives one interrupt request to the core.

Software reaches every register through one write/read port that selects a register by number: count 9, compare 11, status 12, cause 13. Reads are combinational.

Top module: `tmr_irq_ctl`

## Requirements
- R1: On each cycle with `tick` high, the count register (select 9) increases by one and wraps from 0xFFFFFFFF to 0. A write to select 9 loads the written value, and that write takes priority over the tick.
- R2: When the count takes a new value equal to the compare register, cause bit 15 (timer pending) becomes 1. It stays 1 while the count moves on, including when the count register is written.
- R3: Any write to the compare register (select 11) clears cause bit 15. If that write lands in the same cycle as a match, the clear wins.
- R4: The compare register reads back the last value written and never changes by itself. Its value after reset is not specified.
- R5: The status register (select 12) resets to 0x00000004 (ERL set).
  - Writable bits: 28, 24:16, 15:8 (mask IM7..IM0), 7:3, 2 (ERL), 1 (EXL) and 0 (IE).
  - Every other bit reads 0.
- R6: Status bit 25 (reverse endian) always reads 0, and writes that set it have no effect.
- R7: `irq_req` is 1 exactly when IE=1, EXL=0, ERL=0 and some cause bit 8+k is 1 while its status mask bit 8+k is also 1. Mask bit 15 gates the timer, bits 14:10 gate the hardware lines and bits 9:8 gate the software bits.
- R8: Hardware line `hw_irq[i]` is registered once and shows in cause bit 10+i one cycle later. Lines 3 and 4 are tied off, so cause bits 13 and 14 always read 0.
- R9: A write to the cause register (select 13) sets cause bits 9:8 (software pending). Writes to every other cause bit are ignored, and those bits read as their pending state or as 0.
- R10: If the timer is already pending when IM7 or IE becomes enabled, `irq_req` rises at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| hw_irq | input | 5 | Hardware interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The assertions take two things for granted. First, `reg_wr`, `reg_sel` and `tick` are stable around the clock edge. Second, the select value has meaning only while `reg_wr` is high. The bench meets both by driving every input on the falling edge and dropping the write strobe after one cycle. The compare-stability and count-increment properties assume no write to that register in the same cycle, so the bench only overlaps a tick with a compare write in the deliberate priority case. It never reads the compare register before first writing it.

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int SEL_W = 5,
  parameter int HW_N = 5,
  parameter logic [SEL_W-1:0] SEL_CNT = 5'd9,
  parameter logic [SEL_W-1:0] SEL_CMP = 5'd11,
  parameter logic [SEL_W-1:0] SEL_STS = 5'd12,
  parameter logic [SEL_W-1:0] SEL_CAU = 5'd13,
  parameter logic [HW_N-1:0] HW_LIVE = 5'b00111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [HW_N-1:0]  hw_irq,
  output logic             irq_req
);
  localparam logic [31:0] STS_WMASK = 32'h11FF_FFFF;
  localparam logic [31:0] STS_RST   = 32'h0000_0004;

  logic [31:0]     cnt_q, cmp_q, sts_q;
  logic [1:0]      swp_q;
  logic            tpend_q;
  logic [HW_N-1:0] hw_q;

  wire wr_cnt = reg_wr && reg_sel == SEL_CNT;
  wire wr_cmp = reg_wr && reg_sel == SEL_CMP;
  wire wr_sts = reg_wr && reg_sel == SEL_STS;
  wire wr_cau = reg_wr && reg_sel == SEL_CAU;

  wire [31:0] cnt_nxt = wr_cnt ? reg_wdata : cnt_q + 32'd1;
  wire        cnt_upd = wr_cnt || tick;
  wire        hit     = cnt_upd && cnt_nxt == cmp_q;

  wire [7:0] ip = {tpend_q, hw_q & HW_LIVE, swp_q};
  wire [7:0] im = sts_q[15:8];
  wire       ie = sts_q[0], exl = sts_q[1], erl = sts_q[2];

  assign irq_req = ie && !exl && !erl && |(ip & im);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_q   <= '0;
      sts_q   <= STS_RST;
      swp_q   <= '0;
      tpend_q <= 1'b0;
      hw_q    <= '0;
    end else begin
      hw_q <= hw_irq;
      if (cnt_upd) cnt_q <= cnt_nxt;
      if (wr_cmp) cmp_q <= reg_wdata;
      if (wr_sts) sts_q <= reg_wdata & STS_WMASK;
      if (wr_cau) swp_q <= reg_wdata[9:8];
      if (wr_cmp) tpend_q <= 1'b0;
      else if (hit) tpend_q <= 1'b1;
    end

  always_comb
    case (reg_sel)
      SEL_CNT: reg_rdata = cnt_q;
      SEL_CMP: reg_rdata = cmp_q;
      SEL_STS: reg_rdata = sts_q;
      SEL_CAU: reg_rdata = {16'b0, ip, 8'b0};
      default: reg_rdata = '0;
    endcase

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt) |=> cnt_q == $past(cnt_q) + 32'd1);
  a_r2_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tpend_q) |-> cnt_q == cmp_q);
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !tpend_q);
  a_r4_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmp |=> $stable(cmp_q));
  a_r6_no_reverse: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_q[25]);
  a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (sts_q[0] && !sts_q[2:1] && (reg_sel != SEL_CAU || |(reg_rdata[15:8] & sts_q[15:8]))));
endmodule

// File: tb/tmr_irq_ctl_test.sv
module tmr_irq_ctl_test;
  logic clk = 0, rst_n = 0, tick = 0, reg_wr = 0;
  logic [4:0] reg_sel = 0, hw_irq = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_req;
  int checks = 0, fails = 0;
  bit done = 0;

  tmr_irq_ctl uut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_irq(hw_irq), .irq_req(irq_req));

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] s, logic [31:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic ticks(int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12, v); chk("R5 status reset", v, 32'h4);
    rd(13, v); chk("R8 cause reset", v, 0);
    rd(9, v);  chk("R1 count reset", v, 0);
    chk("R7 req after reset", irq_req, 0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(11, 32'h7000_0000);
    wr(9, 5); ticks(3); rd(9, v); chk("R1 increment", v, 8);
    wr(9, 32'hFFFF_FFFF); ticks(1); rd(9, v); chk("R1 wrap", v, 0);
    tick = 1; wr(9, 40); tick = 0; rd(9, v); chk("R1 write beats tick", v, 40);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(12, 32'hFFFF_FFFF); rd(12, v);
    chk("R5 writable bits", v, 32'h11FF_FFFF);
    chk("R6 reverse endian stays 0", v[25], 0);
    wr(12, 32'h0200_0000); rd(12, v); chk("R6 lone RE write", v, 0);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(12, 0); wr(11, 20); wr(9, 17);
    ticks(2); rd(13, v); chk("R2 no early pend", v[15], 0);
    ticks(1); rd(13, v); chk("R2 pend on match", v[15], 1);
    ticks(4); rd(13, v); chk("R2 pend sticky", v[15], 1);
    wr(9, 100); rd(13, v); chk("R2 count write keeps pend", v[15], 1);
    chk("R7 masked timer", irq_req, 0);
  endtask

  task automatic t_enable;
    wr(12, 32'h0000_8000); chk("R10 IM7 without IE", irq_req, 0);
    wr(12, 32'h0000_8001); chk("R10 late enable raises req", irq_req, 1);
    wr(12, 32'h0000_8003); chk("R7 EXL blocks", irq_req, 0);
    wr(12, 32'h0000_8005); chk("R7 ERL blocks", irq_req, 0);
    wr(12, 32'h0000_4001); chk("R7 wrong mask bit", irq_req, 0);
    wr(12, 32'h0000_8001);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(11, 32'h0000_03E7); rd(13, v); chk("R3 compare write clears", v[15], 0);
    chk("R3 req drops", irq_req, 0);
    wr(11, 10); wr(9, 9);
    tick = 1; wr(11, 10); tick = 0;
    rd(9, v); chk("R1 count moved", v, 10);
    rd(13, v); chk("R3 clear beats match", v[15], 0);
  endtask

  task automatic t_compare;
    logic [31:0] v;
    wr(11, 32'hDEAD_BEEF); rd(11, v); chk("R4 readback", v, 32'hDEAD_BEEF);
    ticks(5); rd(11, v); chk("R4 holds", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_hw;
    logic [31:0] v;
    wr(12, 32'h0000_0401);
    hw_irq = 5'b11111; @(negedge clk);
    rd(13, v); chk("R8 live lines only", v, 32'h0000_1C00);
    chk("R7 hw line 0 request", irq_req, 1);
    hw_irq = 5'b11000; @(negedge clk);
    wr(12, 32'h0000_FF01);
    rd(13, v); chk("R8 tied lines", v, 0);
    chk("R8 tied lines no req", irq_req, 0);
    hw_irq = 0; @(negedge clk);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    wr(12, 32'h0000_0101);
    wr(13, 32'hFFFF_FFFF); rd(13, v); chk("R9 only soft bits set", v, 32'h0000_0300);
    chk("R9 soft req", irq_req, 1);
    wr(13, 0); rd(13, v); chk("R9 soft clear", v, 0);
    chk("R9 req drops", irq_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset; t_count; t_status; t_match; t_enable;
    t_clear; t_compare; t_hw; t_soft;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule